// File: doc/BRIEF.md
# Three-Multiplier Complex Multiply-Accumulate Unit

This block multiplies two complex numbers, x = a + jb and y = c + jd, and adds the product into a pair of wide accumulators, one for the real part and one for the imaginary part. It uses three real multipliers in place of four. The three partial products are p1 = c(a+b), p2 = a(d−c) and p3 = b(c+d). The product is then assembled as real = p1 − p3 and imaginary = p1 + p2. The sums feeding the multipliers are one bit wider than the operands, so each multiplier is 16 × 17 bits. The products are kept at full precision.

In filter and transform loops the factor c + jd is often a fixed coefficient. For that case, a coefficient-constant flag lets the caller supply d−c and c+d already computed. The unit then skips two of its pre-additions and ignores the d operand.

The datapath has three register stages: pre-add, multiply, then post-add and accumulate. A new operation may be issued on every clock. Each operation is one of four: clear, load product, add product or subtract product. Both accumulators are 40 bits wide, which leaves guard bits for long sums.

Top module: `cmac3_top`

## Requirements
- R1: After reset, and while reset is held, both accumulators read zero. The reset is active-low and asynchronous.
- R2: The product uses full precision for every signed 16-bit operand, including −32768. Real = a·c − b·d and imaginary = a·d + b·c, with both values sign-extended to the accumulator width.
- R3: The operation code is sampled with `issue` and is encoded as follows: 2'b00 clear, 2'b01 load product, 2'b10 add product, 2'b11 subtract product.
- R4: A clear operation sets both accumulators to zero.
- R5: A load operation replaces both accumulators with the product.
- R6: An add operation adds the product's real part to the real accumulator and the imaginary part to the imaginary accumulator.
- R7: A subtract operation subtracts the product's parts from the matching accumulators.
- R8: An operation issued with `issue` high at rising edge n is visible on the accumulator outputs after rising edge n+2, and not before. Operations issued on consecutive cycles are all applied, in issue order.
- R9: While `issue` is low, the accumulators do not change, whatever the values on the other inputs.
- R10: When `coef_fixed` is high, the unit uses `sum_dmc` as d−c and `sum_cpd` as c+d, each a signed 17-bit value. It ignores the `d` input, and the result equals the product formed with the d those sums imply.
- R11: The accumulators are 40 bits wide. Sixty-four additions of the largest-magnitude product give the exact sum, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Operation valid for this cycle |
| opc | input | 2 | Operation code (see R3) |
| coef_fixed | input | 1 | Use the supplied coefficient sums |
| op_a | input | 16 | Real part of x, signed |
| op_b | input | 16 | Imaginary part of x, signed |
| op_c | input | 16 | Real part of y, signed |
| op_d | input | 16 | Imaginary part of y, signed |
| sum_dmc | input | 17 | Supplied d−c, signed |
| sum_cpd | input | 17 | Supplied c+d, signed |
| acc_re | output | 40 | Real accumulator, signed |
| acc_im | output | 40 | Imaginary accumulator, signed |

## Verification
Every expected result comes from the direct four-product formula a·c − b·d and a·d + b·c, never from the three-product route. Any slip in the pre-adders, the decomposition or the width handling therefore appears as a mismatch. The operand table mixes small values, all −1, all −32768 and mixed extremes of both signs. The all −32768 and mixed-extreme rows separate a correctly widened 17-bit sum from one that wraps at 16 bits. Sequences issued back to back separate correct per-cycle forwarding from dropped or reordered operations. Fixed-coefficient runs drive a false `op_d` to show that the supplied sums alone decide the result. Sixty-four worst-case additions show the guard bits absorb the growth.

// File: rtl/cmac3_pkg.sv
package cmac3_pkg;

    typedef enum logic [1:0] {
        OP_CLR = 2'b00,
        OP_LD  = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } cmac_op_e;

endpackage

// File: rtl/cmac3_preadd.sv
module cmac3_preadd #(
    parameter int DW = 16,
    localparam int SW = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [1:0]    op_i,
    input  logic          fixed_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] c_i,
    input  logic [DW-1:0] d_i,
    input  logic [SW-1:0] dmc_i,
    input  logic [SW-1:0] cpd_i,
    output logic          vld_o,
    output logic [1:0]    op_o,
    output logic [DW-1:0] a_o,
    output logic [DW-1:0] b_o,
    output logic [DW-1:0] c_o,
    output logic [SW-1:0] sab_o,
    output logic [SW-1:0] sdc_o,
    output logic [SW-1:0] scd_o
);

    typedef struct packed {
        logic          vld;
        logic [1:0]    op;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] c;
        logic [SW-1:0] sab;
        logic [SW-1:0] sdc;
        logic [SW-1:0] scd;
    } pre_st_t;

    pre_st_t st_d, st_q;

    logic [SW-1:0] ax, bx, cx, dx;

    always_comb begin
        ax = {a_i[DW-1], a_i};
        bx = {b_i[DW-1], b_i};
        cx = {c_i[DW-1], c_i};
        dx = {d_i[DW-1], d_i};

        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.op  = op_i;
            st_d.a   = a_i;
            st_d.b   = b_i;
            st_d.c   = c_i;
            st_d.sab = ax + bx;
            if (fixed_i) begin
                st_d.sdc = dmc_i;
                st_d.scd = cpd_i;
            end else begin
                st_d.sdc = dx - cx;
                st_d.scd = cx + dx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign op_o  = st_q.op;
    assign a_o   = st_q.a;
    assign b_o   = st_q.b;
    assign c_o   = st_q.c;
    assign sab_o = st_q.sab;
    assign sdc_o = st_q.sdc;
    assign scd_o = st_q.scd;

endmodule

// File: rtl/cmac3_mults.sv
module cmac3_mults #(
    parameter int DW = 16,
    parameter int NM = 3,
    localparam int SW = DW + 1,
    localparam int PW = DW + SW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vld_i,
    input  logic [1:0]             op_i,
    input  logic [NM-1:0][DW-1:0]  x_i,
    input  logic [NM-1:0][SW-1:0]  y_i,
    output logic                   vld_o,
    output logic [1:0]             op_o,
    output logic [NM-1:0][PW-1:0]  p_o
);

    typedef struct packed {
        logic                  vld;
        logic [1:0]            op;
        logic [NM-1:0][PW-1:0] p;
    } mul_st_t;

    mul_st_t st_d, st_q;

    logic [PW-1:0] prod_w [NM];

    for (genvar g = 0; g < NM; g++) begin : g_mul
        logic signed [PW-1:0] xe, ye;
        assign xe = $signed({{SW{x_i[g][DW-1]}}, x_i[g]});
        assign ye = $signed({{DW{y_i[g][SW-1]}}, y_i[g]});
        assign prod_w[g] = xe * ye;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.op = op_i;
            for (int i = 0; i < NM; i++) begin
                st_d.p[i] = prod_w[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign op_o  = st_q.op;
    assign p_o   = st_q.p;

endmodule

// File: rtl/cmac3_acc.sv
module cmac3_acc
    import cmac3_pkg::*;
#(
    parameter int PW = 33,
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [1:0]    op_i,
    input  logic [PW-1:0] k1_i,
    input  logic [PW-1:0] k2_i,
    input  logic [PW-1:0] k3_i,
    output logic [AW-1:0] re_o,
    output logic [AW-1:0] im_o
);

    localparam int EXT = AW - PW;

    typedef struct packed {
        logic [AW-1:0] re;
        logic [AW-1:0] im;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic [AW-1:0] k1x, k2x, k3x, pre, pim;

    always_comb begin
        k1x = {{EXT{k1_i[PW-1]}}, k1_i};
        k2x = {{EXT{k2_i[PW-1]}}, k2_i};
        k3x = {{EXT{k3_i[PW-1]}}, k3_i};
        pre = k1x - k3x;
        pim = k1x + k2x;

        st_d = st_q;
        if (vld_i) begin
            case (cmac_op_e'(op_i))
                OP_CLR: begin
                    st_d.re = '0;
                    st_d.im = '0;
                end
                OP_LD: begin
                    st_d.re = pre;
                    st_d.im = pim;
                end
                OP_ADD: begin
                    st_d.re = st_q.re + pre;
                    st_d.im = st_q.im + pim;
                end
                default: begin
                    st_d.re = st_q.re - pre;
                    st_d.im = st_q.im - pim;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign re_o = st_q.re;
    assign im_o = st_q.im;

endmodule

// File: rtl/cmac3_top.sv
module cmac3_top #(
    parameter int DW = 16,
    parameter int AW = 40,
    localparam int SW = DW + 1,
    localparam int PW = DW + SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [1:0]    opc,
    input  logic          coef_fixed,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [DW-1:0] op_c,
    input  logic [DW-1:0] op_d,
    input  logic [SW-1:0] sum_dmc,
    input  logic [SW-1:0] sum_cpd,
    output logic [AW-1:0] acc_re,
    output logic [AW-1:0] acc_im
);

    logic          s1_vld;
    logic [1:0]    s1_op;
    logic [DW-1:0] s1_a, s1_b, s1_c;
    logic [SW-1:0] s1_sab, s1_sdc, s1_scd;

    logic                 s2_vld;
    logic [1:0]           s2_op;
    logic [2:0][PW-1:0]   s2_p;
    logic [PW-1:0]        k1_q, k2_q, k3_q;

    cmac3_preadd #(.DW(DW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (issue),
        .op_i    (opc),
        .fixed_i (coef_fixed),
        .a_i     (op_a),
        .b_i     (op_b),
        .c_i     (op_c),
        .d_i     (op_d),
        .dmc_i   (sum_dmc),
        .cpd_i   (sum_cpd),
        .vld_o   (s1_vld),
        .op_o    (s1_op),
        .a_o     (s1_a),
        .b_o     (s1_b),
        .c_o     (s1_c),
        .sab_o   (s1_sab),
        .sdc_o   (s1_sdc),
        .scd_o   (s1_scd)
    );

    // lane 0: c*(a+b), lane 1: a*(d-c), lane 2: b*(c+d)
    cmac3_mults #(.DW(DW), .NM(3)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (s1_vld),
        .op_i  (s1_op),
        .x_i   ({s1_b, s1_a, s1_c}),
        .y_i   ({s1_scd, s1_sdc, s1_sab}),
        .vld_o (s2_vld),
        .op_o  (s2_op),
        .p_o   (s2_p)
    );

    assign k1_q = s2_p[0];
    assign k2_q = s2_p[1];
    assign k3_q = s2_p[2];

    cmac3_acc #(.PW(PW), .AW(AW)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (s2_vld),
        .op_i  (s2_op),
        .k1_i  (k1_q),
        .k2_i  (k2_q),
        .k3_i  (k3_q),
        .re_o  (acc_re),
        .im_o  (acc_im)
    );

endmodule

// File: rtl/cmac3_chk.sv
module cmac3_chk
    import cmac3_pkg::*;
#(
    parameter int PW = 33,
    parameter int AW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue,
    input logic [1:0]    opc,
    input logic [PW-1:0] k1,
    input logic [PW-1:0] k2,
    input logic [PW-1:0] k3,
    input logic [AW-1:0] acc_re,
    input logic [AW-1:0] acc_im
);

    localparam int EXT = AW - PW;

    logic [2:0]      vsr;
    logic [2:0][1:0] osr;
    logic            seen;
    logic [AW-1:0]   p_re, p_im;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsr <= '0;
            osr <= '0;
        end else begin
            vsr <= {vsr[1:0], issue};
            osr <= {osr[1:0], opc};
        end
    end

    always_ff @(posedge clk) seen <= 1'b1;

    assign p_re = {{EXT{k1[PW-1]}}, k1} - {{EXT{k3[PW-1]}}, k3};
    assign p_im = {{EXT{k1[PW-1]}}, k1} + {{EXT{k2[PW-1]}}, k2};

    a_r1_reset_zero: assert property (@(posedge clk)
        (seen && !$past(rst_n)) |-> (acc_re == '0 && acc_im == '0));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (vsr[2] && osr[2] == OP_CLR) |-> (acc_re == '0 && acc_im == '0));

    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        (vsr[2] && osr[2] == OP_LD) |-> (acc_re == $past(p_re) && acc_im == $past(p_im)));

    a_r6_add: assert property (@(posedge clk) disable iff (!rst_n)
        (vsr[2] && osr[2] == OP_ADD) |->
        (acc_re == $past(acc_re) + $past(p_re) && acc_im == $past(acc_im) + $past(p_im)));

    a_r7_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (vsr[2] && osr[2] == OP_SUB) |->
        (acc_re == $past(acc_re) - $past(p_re) && acc_im == $past(acc_im) - $past(p_im)));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vsr[2] |-> ($stable(acc_re) && $stable(acc_im)));

endmodule

bind cmac3_top cmac3_chk #(.PW(PW), .AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (issue),
    .opc    (opc),
    .k1     (k1_q),
    .k2     (k2_q),
    .k3     (k3_q),
    .acc_re (acc_re),
    .acc_im (acc_im)
);

// File: tb/sim_cmac3_top.sv
module sim_cmac3_top;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               issue = 1'b0;
    logic [1:0]         opc = 2'b00;
    logic               coef_fixed = 1'b0;
    logic signed [15:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
    logic signed [16:0] sum_dmc = '0, sum_cpd = '0;
    logic [39:0]        acc_re, acc_im;

    int n_chk = 0;
    int n_bad = 0;
    longint e_re = 0;
    longint e_im = 0;

    localparam logic [1:0] CLR = 2'b00, LD = 2'b01, ADD = 2'b10, SUB = 2'b11;

    // each row: {a, b, c, d}
    localparam int NV = 10;
    localparam logic [63:0] VEC [NV] = '{
        64'h0001_0002_0003_0004,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_8000_8000_8000,
        64'h8000_7FFF_8000_7FFF,
        64'h7FFF_7FFF_7FFF_7FFF,
        64'h8000_0000_7FFF_8000,
        64'h1234_ABCD_5678_9ABC,
        64'h0000_8000_8000_7FFF,
        64'h7FFF_8000_8000_7FFF,
        64'h0005_FFFB_FFFD_0007
    };

    cmac3_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .opc        (opc),
        .coef_fixed (coef_fixed),
        .op_a       (op_a),
        .op_b       (op_b),
        .op_c       (op_c),
        .op_d       (op_d),
        .sum_dmc    (sum_dmc),
        .sum_cpd    (sum_cpd),
        .acc_re     (acc_re),
        .acc_im     (acc_im)
    );

    always #10 clk = ~clk;

    function automatic longint dir_re(logic signed [15:0] a, b, c, d);
        return longint'(a) * longint'(c) - longint'(b) * longint'(d);
    endfunction

    function automatic longint dir_im(logic signed [15:0] a, b, c, d);
        return longint'(a) * longint'(d) + longint'(b) * longint'(c);
    endfunction

    task automatic model(input logic [1:0] o, input longint pr, input longint pi);
        case (o)
            CLR: begin e_re = 0; e_im = 0; end
            LD:  begin e_re = pr; e_im = pi; end
            ADD: begin e_re += pr; e_im += pi; end
            default: begin e_re -= pr; e_im -= pi; end
        endcase
    endtask

    // drive one operation right after a falling edge, advance one cycle
    task automatic put(input logic [1:0] o, input logic signed [15:0] a, b, c, d);
        issue = 1'b1; opc = o; coef_fixed = 1'b0;
        op_a = a; op_b = b; op_c = c; op_d = d;
        model(o, dir_re(a, b, c, d), dir_im(a, b, c, d));
        @(negedge clk);
    endtask

    task automatic put_fixed(input logic [1:0] o, input logic signed [15:0] a, b, c, dtrue,
                             input logic signed [15:0] djunk);
        issue = 1'b1; opc = o; coef_fixed = 1'b1;
        op_a = a; op_b = b; op_c = c; op_d = djunk;
        sum_dmc = 17'(longint'(dtrue) - longint'(c));
        sum_cpd = 17'(longint'(c) + longint'(dtrue));
        model(o, dir_re(a, b, c, dtrue), dir_im(a, b, c, dtrue));
        @(negedge clk);
    endtask

    task automatic flush();
        issue = 1'b0; coef_fixed = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic chk(input string tag, input longint er, input longint ei);
        n_chk++;
        if (acc_re !== er[39:0] || acc_im !== ei[39:0]) begin
            n_bad++;
            $display("FAIL %s: got re=%h im=%h expected re=%h im=%h",
                     tag, acc_re, acc_im, er[39:0], ei[39:0]);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 held in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 0, 0);

        // table: load each product, compare with direct formula
        for (int i = 0; i < NV; i++) begin
            put(LD, VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
            flush();
            chk($sformatf("R2 R3 R5 load row %0d", i), e_re, e_im);
        end

        // R4: clear after nonzero contents
        put(CLR, 16'sd9, 16'sd9, 16'sd9, 16'sd9);
        flush();
        chk("R4 clear", 0, 0);

        // R8: exact latency
        put(LD, 16'sd300, -16'sd7, 16'sd11, 16'sd5);
        issue = 1'b0;
        @(negedge clk);
        chk("R8 not yet visible", 0, 0);
        @(negedge clk);
        chk("R8 visible after third edge", e_re, e_im);

        // R6 R8: back-to-back additions of all rows
        put(CLR, 0, 0, 0, 0);
        for (int i = 0; i < NV; i++)
            put(ADD, VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
        flush();
        chk("R6 R8 back-to-back add", e_re, e_im);

        // R7: back-to-back subtractions
        for (int i = 0; i < 6; i++)
            put(SUB, VEC[i][15:0], VEC[i][63:48], VEC[i][47:32], VEC[i][31:16]);
        flush();
        chk("R7 back-to-back subtract", e_re, e_im);

        // R9: issue low, other inputs active
        opc = CLR; op_a = 16'sh7FFF; op_b = 16'sh8000; coef_fixed = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 idle clear ignored", e_re, e_im);
        opc = ADD; coef_fixed = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 idle add ignored", e_re, e_im);

        // R10: supplied sums, false d on the port
        put(CLR, 0, 0, 0, 0);
        put_fixed(LD, 16'sd1234, -16'sd77, 16'sd500, -16'sd321, 16'sh7FFF);
        flush();
        chk("R10 fixed load", e_re, e_im);
        put_fixed(ADD, 16'sh8000, 16'sh8000, 16'sh8000, 16'sh7FFF, 16'sd0);
        put_fixed(SUB, 16'sh7FFF, 16'sh8000, 16'sh7FFF, 16'sh8000, 16'sd1);
        flush();
        chk("R10 fixed extremes", e_re, e_im);

        // R11: 64 worst-case additions without wrap
        put(CLR, 0, 0, 0, 0);
        for (int i = 0; i < 64; i++)
            put(ADD, 16'sh8000, 16'sh8000, 16'sh8000, 16'sh7FFF);
        flush();
        chk("R11 64 worst additions", e_re, e_im);
        for (int i = 0; i < 64; i++)
            put(SUB, 16'sh8000, 16'sh7FFF, 16'sh8000, 16'sh8000);
        flush();
        chk("R11 64 worst subtractions", e_re, e_im);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset", 0, 0);
        rst_n = 1'b1;
        e_re = 0; e_im = 0;
        @(negedge clk);
        chk("R1 released", 0, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule